// File: doc/BRIEF.md
# Two-Level Address Translation Cache with Two Page Sizes

This block turns a virtual address into a physical address. It handles two page granularities, 4 KB and 2 MB. Each granularity has its own small fully associative first-level array and its own larger direct-mapped second-level array. The page size of an address cannot be known before the lookup, so every step probes both sizes in parallel. The first-level arrays are probed first. If neither of them holds the page, both second-level arrays are probed in the following cycle. Only when all four arrays miss does the block ask an external page-table walker for the mapping. It then waits for the refill, which states the page size, and installs the entry in the arrays of that size.

The block handles one lookup at a time. The lookup request, the response, the walk request and the refill all use valid/ready handshakes. `req_ready` is high only while no lookup is in flight. A response, once raised, stays valid and unchanged until `rsp_ready` is seen high at a clock edge. A walk request stays valid with a stable address until `walk_req_ready` is seen high. `refill_ready` is high only while the block waits for a refill. The invalidate input is a plain level control.

Top module: `tlb_two_level`

## Requirements
- R1: `req_ready` is high only in the idle state, so `req_ready` and `rsp_valid` are never high together. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold their values into the next cycle.
- R2: On a first-level hit, `rsp_valid` rises one clock edge after the edge that accepts the request, with `rsp_hit`=1 and `rsp_walked`=0.
- R3: A second-level hit that missed the first level responds two clock edges after the accept edge. The entry is copied into the first-level array of the same page size, so the next lookup of that page answers with first-level timing.
- R4: When both levels miss, `walk_req_valid` rises with `walk_vaddr` equal to the requested address. It holds until `walk_req_ready` is high. The block then holds `refill_ready` high until `refill_valid` arrives. The response carries the refilled translation with `rsp_hit`=1 and `rsp_walked`=1.
- R5: `refill_big` selects the page size, 0 for 4 KB and 1 for 2 MB. The refill is written into both the first-level and the second-level array of that size, and later hits report `rsp_big` equal to it.
- R6: For a 4 KB page, `rsp_paddr` = {page base bits [PA_W-1:12], vaddr[11:0]}. For a 2 MB page, `rsp_paddr` = {page base bits [PA_W-1:21], vaddr[20:0]}. Tags compare only the virtual bits above the offset, so any address inside a cached page hits.
- R7: When both page sizes hit at the same level, the 4 KB entry wins: `rsp_big`=0 and `rsp_multi`=1.
- R8: Each first-level array replaces entries round robin. After L1_N+1 distinct installs of one size, the first page installed is gone from the first level but still hits in the second level.
- R9: Each second-level array is direct-mapped and indexed by the low log2(L2_SETS) bits of the virtual page number. Two pages with equal index bits evict each other.
- R10: `inval_all` clears every valid bit in all four arrays at the next edge and wins over any write in that cycle. A request accepted while it is high responds right after the accept edge with `rsp_hit`=0 and no walk.
- R11: During and after reset: `req_ready`=1, `rsp_valid`=0, `walk_req_valid`=0, `refill_ready`=0, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_all | input | 1 | Clear all entries |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | 1: translation returned, 0: miss |
| rsp_big | output | 1 | Translation is a 2 MB page |
| rsp_multi | output | 1 | Both page sizes matched |
| rsp_walked | output | 1 | Translation came from a walk |
| rsp_paddr | output | PA_W | Physical address |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_vaddr | output | VA_W | Address to walk |
| refill_valid | input | 1 | Refill data valid |
| refill_ready | output | 1 | Block waits for refill |
| refill_big | input | 1 | Refill page size (1 = 2 MB) |
| refill_pbase | input | PA_W | Physical page base |

## Verification
The bench builds the block with L1_N=2 and L2_SETS=4, keeping the default address widths of 39 virtual and 40 physical bits. Two first-level entries per size mean that a third install evicts the first, so round-robin victims and promotion back from the second level can be reached in a few lookups. Four second-level sets make it easy to pick pages whose virtual page numbers differ by four and so collide in one set. The 39/40-bit widths keep both offset splits and a 2 MB region that holds 4 KB pages of its own, which is what a same-level hit on both sizes needs.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_WREQ,
    ST_WWAIT,
    ST_RSP
  } tlb_state_e;

  localparam int OFS_SMALL = 12;
  localparam int OFS_LARGE = 21;
endpackage

// File: rtl/tlb_l1_fa.sv
`timescale 1ns/1ps
module tlb_l1_fa #(
  parameter int N      = 8,
  parameter int TAG_W  = 27,
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      vld;
  logic [TAG_W-1:0]  tag_q [N];
  logic [DATA_W-1:0] dat_q [N];
  logic [N-1:0]      match;
  logic [PTR_W-1:0]  victim;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag_q[g] == lk_tag);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) lk_data = lk_data | dat_q[i];
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_en && !flush && victim == PTR_W'(i)) begin
        tag_q[i] <= wr_tag;
        dat_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      victim <= '0;
    end else if (flush) begin
      vld    <= '0;
    end else if (wr_en) begin
      vld[victim] <= 1'b1;
      victim      <= (victim == PTR_W'(N-1)) ? '0 : victim + PTR_W'(1);
    end
  end
endmodule

// File: rtl/tlb_l2_dm.sv
`timescale 1ns/1ps
module tlb_l2_dm #(
  parameter int SETS   = 32,
  parameter int VPN_W  = 27,
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [SETS-1:0]   vld;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign wr_idx  = wr_vpn[IDX_W-1:0];
  assign lk_hit  = vld[lk_idx] && (tag_q[lk_idx] == lk_vpn[VPN_W-1:IDX_W]);
  assign lk_data = dat_q[lk_idx];

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_vpn[VPN_W-1:IDX_W];
      dat_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (flush) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end
endmodule

// File: rtl/tlb_two_level.sv
`timescale 1ns/1ps
module tlb_two_level
  import tlb_pkg::*;
#(
  parameter int VA_W    = 39,
  parameter int PA_W    = 40,
  parameter int L1_N    = 8,
  parameter int L2_SETS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inval_all,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_hit,
  output logic            rsp_big,
  output logic            rsp_multi,
  output logic            rsp_walked,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            walk_req_valid,
  input  logic            walk_req_ready,
  output logic [VA_W-1:0] walk_vaddr,
  input  logic            refill_valid,
  output logic            refill_ready,
  input  logic            refill_big,
  input  logic [PA_W-1:0] refill_pbase
);
  localparam int VS_W = VA_W - OFS_SMALL;
  localparam int VL_W = VA_W - OFS_LARGE;
  localparam int PS_W = PA_W - OFS_SMALL;
  localparam int PL_W = PA_W - OFS_LARGE;

  tlb_state_e      st;
  logic [VA_W-1:0] va_q;
  logic            r_hit, r_big, r_multi, r_walked;
  logic [PA_W-1:0] r_pa;

  logic [VS_W-1:0] vpn_s;
  logic [VL_W-1:0] vpn_l;
  assign vpn_s = va_q[VA_W-1:OFS_SMALL];
  assign vpn_l = va_q[VA_W-1:OFS_LARGE];

  logic            l1s_hit, l1l_hit, l2s_hit, l2l_hit;
  logic [PS_W-1:0] l1s_data, l2s_data, l1s_wdata;
  logic [PL_W-1:0] l1l_data, l2l_data, l1l_wdata;
  logic            l1s_wr, l1l_wr, l2s_wr, l2l_wr, refill_fire;

  assign refill_fire = (st == ST_WWAIT) && refill_valid;

  // promotion from second level, or install of a refill
  assign l1s_wr = ((st == ST_L2) && l2s_hit) || (refill_fire && !refill_big);
  assign l1l_wr = ((st == ST_L2) && !l2s_hit && l2l_hit) || (refill_fire && refill_big);
  assign l2s_wr = refill_fire && !refill_big;
  assign l2l_wr = refill_fire && refill_big;
  assign l1s_wdata = (st == ST_L2) ? l2s_data : refill_pbase[PA_W-1:OFS_SMALL];
  assign l1l_wdata = (st == ST_L2) ? l2l_data : refill_pbase[PA_W-1:OFS_LARGE];

  tlb_l1_fa #(.N(L1_N), .TAG_W(VS_W), .DATA_W(PS_W)) u_l1_small (
    .clk(clk), .rst_n(rst_n), .flush(inval_all),
    .lk_tag(vpn_s), .lk_hit(l1s_hit), .lk_data(l1s_data),
    .wr_en(l1s_wr), .wr_tag(vpn_s), .wr_data(l1s_wdata));

  tlb_l1_fa #(.N(L1_N), .TAG_W(VL_W), .DATA_W(PL_W)) u_l1_large (
    .clk(clk), .rst_n(rst_n), .flush(inval_all),
    .lk_tag(vpn_l), .lk_hit(l1l_hit), .lk_data(l1l_data),
    .wr_en(l1l_wr), .wr_tag(vpn_l), .wr_data(l1l_wdata));

  tlb_l2_dm #(.SETS(L2_SETS), .VPN_W(VS_W), .DATA_W(PS_W)) u_l2_small (
    .clk(clk), .rst_n(rst_n), .flush(inval_all),
    .lk_vpn(vpn_s), .lk_hit(l2s_hit), .lk_data(l2s_data),
    .wr_en(l2s_wr), .wr_vpn(vpn_s), .wr_data(refill_pbase[PA_W-1:OFS_SMALL]));

  tlb_l2_dm #(.SETS(L2_SETS), .VPN_W(VL_W), .DATA_W(PL_W)) u_l2_large (
    .clk(clk), .rst_n(rst_n), .flush(inval_all),
    .lk_vpn(vpn_l), .lk_hit(l2l_hit), .lk_data(l2l_data),
    .wr_en(l2l_wr), .wr_vpn(vpn_l), .wr_data(refill_pbase[PA_W-1:OFS_LARGE]));

  logic [PA_W-1:0] pa_l1s, pa_l1l, pa_l2s, pa_l2l, pa_fill;
  assign pa_l1s  = {l1s_data, va_q[OFS_SMALL-1:0]};
  assign pa_l1l  = {l1l_data, va_q[OFS_LARGE-1:0]};
  assign pa_l2s  = {l2s_data, va_q[OFS_SMALL-1:0]};
  assign pa_l2l  = {l2l_data, va_q[OFS_LARGE-1:0]};
  assign pa_fill = refill_big ? {refill_pbase[PA_W-1:OFS_LARGE], va_q[OFS_LARGE-1:0]}
                              : {refill_pbase[PA_W-1:OFS_SMALL], va_q[OFS_SMALL-1:0]};

  logic unused_base_bits;
  assign unused_base_bits = ^refill_pbase[OFS_SMALL-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      va_q     <= '0;
      r_hit    <= 1'b0;
      r_big    <= 1'b0;
      r_multi  <= 1'b0;
      r_walked <= 1'b0;
      r_pa     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          if (inval_all) begin
            r_hit    <= 1'b0;
            r_big    <= 1'b0;
            r_multi  <= 1'b0;
            r_walked <= 1'b0;
            r_pa     <= '0;
            st       <= ST_RSP;
          end else begin
            st <= ST_L1;
          end
        end
        ST_L1: if (l1s_hit || l1l_hit) begin
          r_hit    <= 1'b1;
          r_big    <= !l1s_hit;
          r_multi  <= l1s_hit && l1l_hit;
          r_walked <= 1'b0;
          r_pa     <= l1s_hit ? pa_l1s : pa_l1l;
          st       <= ST_RSP;
        end else begin
          st <= ST_L2;
        end
        ST_L2: if (l2s_hit || l2l_hit) begin
          r_hit    <= 1'b1;
          r_big    <= !l2s_hit;
          r_multi  <= l2s_hit && l2l_hit;
          r_walked <= 1'b0;
          r_pa     <= l2s_hit ? pa_l2s : pa_l2l;
          st       <= ST_RSP;
        end else begin
          st <= ST_WREQ;
        end
        ST_WREQ: if (walk_req_ready) st <= ST_WWAIT;
        ST_WWAIT: if (refill_valid) begin
          r_hit    <= 1'b1;
          r_big    <= refill_big;
          r_multi  <= 1'b0;
          r_walked <= 1'b1;
          r_pa     <= pa_fill;
          st       <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (st == ST_IDLE);
  assign rsp_valid      = (st == ST_RSP);
  assign rsp_hit        = r_hit;
  assign rsp_big        = r_big;
  assign rsp_multi      = r_multi;
  assign rsp_walked     = r_walked;
  assign rsp_paddr      = r_pa;
  assign walk_req_valid = (st == ST_WREQ);
  assign walk_vaddr     = va_q;
  assign refill_ready   = (st == ST_WWAIT);
endmodule

// File: rtl/tlb_two_level_chk.sv
`timescale 1ns/1ps
module tlb_two_level_chk #(
  parameter int VA_W    = 39,
  parameter int PA_W    = 40,
  parameter int L1_N    = 8,
  parameter int L2_SETS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inval_all,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_hit,
  input logic            rsp_big,
  input logic            rsp_multi,
  input logic            rsp_walked,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            walk_req_valid,
  input logic            walk_req_ready,
  input logic [VA_W-1:0] walk_vaddr
);
  logic [VA_W-1:0] va_cap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_cap <= '0;
    else if (req_valid && req_ready) va_cap <= req_vaddr;
  end

  p_one_inflight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)
                                && $stable(rsp_big) && $stable(rsp_multi) && $stable(rsp_walked));

  p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_vaddr));

  p_walk_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> walk_vaddr == va_cap);

  p_walked_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_walked |-> rsp_hit);

  p_small_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && !rsp_big |-> rsp_paddr[11:0] == va_cap[11:0]);

  p_large_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && rsp_big |-> rsp_paddr[20:0] == va_cap[20:0]);

  p_multi_small_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_multi |-> rsp_hit && !rsp_big);

  p_inval_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && inval_all |=> rsp_valid && !rsp_hit && !walk_req_valid);
endmodule

bind tlb_two_level tlb_two_level_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .L1_N(L1_N), .L2_SETS(L2_SETS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_big(rsp_big), .rsp_multi(rsp_multi), .rsp_walked(rsp_walked),
  .rsp_paddr(rsp_paddr), .walk_req_valid(walk_req_valid),
  .walk_req_ready(walk_req_ready), .walk_vaddr(walk_vaddr)
);

// File: tb/tlb_two_level_tb_top.sv
`timescale 1ns/1ps
module tlb_two_level_tb_top;
  localparam int VA_W    = 39;
  localparam int PA_W    = 40;
  localparam int L1_N    = 2;
  localparam int L2_SETS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inval_all = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_ready = 1'b0;
  logic walk_req_ready = 1'b0;
  logic refill_valid = 1'b0;
  logic refill_big = 1'b0;
  logic [PA_W-1:0] refill_pbase = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_big, rsp_multi, rsp_walked;
  logic [PA_W-1:0] rsp_paddr;
  logic walk_req_valid, refill_ready;
  logic [VA_W-1:0] walk_vaddr;

  always #2.5 clk = ~clk;

  tlb_two_level #(.VA_W(VA_W), .PA_W(PA_W), .L1_N(L1_N), .L2_SETS(L2_SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_big(rsp_big), .rsp_multi(rsp_multi), .rsp_walked(rsp_walked),
    .rsp_paddr(rsp_paddr), .walk_req_valid(walk_req_valid),
    .walk_req_ready(walk_req_ready), .walk_vaddr(walk_vaddr),
    .refill_valid(refill_valid), .refill_ready(refill_ready),
    .refill_big(refill_big), .refill_pbase(refill_pbase));

  int n_chk = 0;
  int n_fail = 0;

  // walker model configuration and results of the last lookup
  logic            cfg_big = 1'b0;
  logic [PA_W-1:0] cfg_base = '0;
  int              cfg_wdelay = 0;
  int              cfg_hold = 0;
  int              lat;
  logic            g_hit, g_big, g_multi, g_walked, g_walk_seen;
  logic [PA_W-1:0] g_pa;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] pa_small(input logic [VA_W-1:0] va, input logic [PA_W-1:0] b);
    return {b[PA_W-1:12], va[11:0]};
  endfunction

  function automatic logic [PA_W-1:0] pa_large(input logic [VA_W-1:0] va, input logic [PA_W-1:0] b);
    return {b[PA_W-1:21], va[20:0]};
  endfunction

  task automatic lookup(input logic [VA_W-1:0] va, input logic inv);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; inval_all = inv;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; inval_all = 1'b0;
    lat = 0; g_walk_seen = 1'b0;
    while (!rsp_valid) begin
      if (walk_req_valid) begin
        g_walk_seen = 1'b1;
        check("R4 walk address", 64'(walk_vaddr), 64'(va));
        for (int i = 0; i < cfg_wdelay; i++) begin
          @(negedge clk); lat++;
          check("R4 walk request held", {63'd0, walk_req_valid}, 64'd1);
          check("R4 walk address stable", 64'(walk_vaddr), 64'(va));
        end
        walk_req_ready = 1'b1;
        @(negedge clk); lat++;
        walk_req_ready = 1'b0;
        check("R4 refill ready", {63'd0, refill_ready}, 64'd1);
        refill_valid = 1'b1; refill_big = cfg_big; refill_pbase = cfg_base;
        @(negedge clk); lat++;
        refill_valid = 1'b0;
      end else begin
        @(negedge clk); lat++;
      end
    end
    g_hit = rsp_hit; g_big = rsp_big; g_multi = rsp_multi;
    g_walked = rsp_walked; g_pa = rsp_paddr;
    for (int i = 0; i < cfg_hold; i++) begin
      @(negedge clk);
      check("R1 response held", {62'd0, rsp_valid, req_ready}, 64'd2);
      check("R1 address stable", 64'(rsp_paddr), 64'(g_pa));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 in reset", {60'd0, req_ready, rsp_valid, walk_req_valid, refill_ready}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", {60'd0, req_ready, rsp_valid, walk_req_valid, refill_ready}, 64'h8);
  endtask

  task automatic t_walk_small();
    logic [VA_W-1:0] a = 39'h00_1234_5678;
    cfg_big = 1'b0; cfg_base = 40'hAB_CDEF_0000;
    lookup(a, 1'b0);
    check("R11 empty after reset walks", {63'd0, g_walk_seen}, 64'd1);
    check("R4 walked flags", {61'd0, g_hit, g_walked, g_big}, 64'h6);
    check("R6 small walk paddr", 64'(g_pa), 64'(pa_small(a, cfg_base)));
    lookup(a + 39'h10, 1'b0);
    check("R2 l1 latency", 64'(lat), 64'd1);
    check("R2 l1 hit no walk", {62'd0, g_hit, g_walked}, 64'h2);
    check("R6 small hit paddr", 64'(g_pa), 64'(pa_small(a + 39'h10, cfg_base)));
  endtask

  task automatic t_walk_large();
    logic [VA_W-1:0] b = 39'h00_4020_1234;
    logic [PA_W-1:0] base = 40'h55_0020_0000;
    cfg_big = 1'b1; cfg_base = base;
    lookup(b, 1'b0);
    check("R5 large walk", {61'd0, g_hit, g_walked, g_big}, 64'h7);
    check("R6 large walk paddr", 64'(g_pa), 64'(pa_large(b, base)));
    lookup(b + 39'h1F_0000, 1'b0);
    check("R5 large l1 hit", {61'd0, g_hit, g_walked, g_big}, 64'h5);
    check("R2 large l1 latency", 64'(lat), 64'd1);
    check("R6 large offset passes", 64'(g_pa), 64'(pa_large(b + 39'h1F_0000, base)));
  endtask

  task automatic t_inval();
    logic [VA_W-1:0] a = 39'h00_1234_5000;
    lookup(a, 1'b1);
    check("R10 inval request latency", 64'(lat), 64'd0);
    check("R10 inval request misses", {61'd0, g_hit, g_walked, g_walk_seen}, 64'd0);
    cfg_big = 1'b0; cfg_base = 40'h11_2233_4000;
    lookup(a, 1'b0);
    check("R10 cleared entry walks", {63'd0, g_walk_seen}, 64'd1);
    check("R10 new translation", 64'(g_pa), 64'(pa_small(a, cfg_base)));
  endtask

  task automatic t_multi();
    logic [VA_W-1:0] c = 39'h30_0040_3000;
    logic [VA_W-1:0] d = 39'h30_0040_8000;
    logic [PA_W-1:0] bs = 40'h0A_0000_7000;
    logic [PA_W-1:0] bl = 40'h0B_0020_0000;
    lookup(39'h0, 1'b1);
    cfg_big = 1'b0; cfg_base = bs;
    lookup(c, 1'b0);
    cfg_big = 1'b1; cfg_base = bl;
    lookup(d, 1'b0);
    check("R5 large refill inside region", {62'd0, g_walk_seen, g_big}, 64'h3);
    lookup(c + 39'h44, 1'b0);
    check("R7 small page wins", {61'd0, g_hit, g_multi, g_big}, 64'h6);
    check("R7 small paddr", 64'(g_pa), 64'(pa_small(c + 39'h44, bs)));
    lookup(d + 39'h8, 1'b0);
    check("R7 single size no flag", {61'd0, g_hit, g_multi, g_big}, 64'h5);
  endtask

  task automatic t_promote();
    logic [VA_W-1:0] p1 = 39'h10_0000_1000;
    logic [VA_W-1:0] p2 = 39'h10_0000_2000;
    logic [VA_W-1:0] p3 = 39'h10_0000_3000;
    lookup(39'h0, 1'b1);
    cfg_big = 1'b0;
    cfg_base = 40'h01_0000_1000; lookup(p1, 1'b0);
    cfg_base = 40'h01_0000_2000; lookup(p2, 1'b0);
    cfg_base = 40'h01_0000_3000; lookup(p3, 1'b0);
    lookup(p1 + 39'h20, 1'b0);
    check("R8 evicted from l1 l2 still hits", {62'd0, g_hit, g_walk_seen}, 64'h2);
    check("R3 l2 latency", 64'(lat), 64'd2);
    check("R3 l2 paddr", 64'(g_pa), 64'(pa_small(p1 + 39'h20, 40'h01_0000_1000)));
    lookup(p1, 1'b0);
    check("R3 promoted to l1", 64'(lat), 64'd1);
  endtask

  task automatic t_direct_mapped();
    logic [VA_W-1:0] q0 = 39'h20_0000_0000;
    logic [VA_W-1:0] q4 = 39'h20_0000_4000;
    logic [VA_W-1:0] q5 = 39'h20_0000_5000;
    lookup(39'h0, 1'b1);
    cfg_big = 1'b0;
    cfg_base = 40'h02_0000_0000; lookup(q0, 1'b0);
    cfg_base = 40'h02_0000_4000; lookup(q4, 1'b0);
    cfg_base = 40'h02_0000_5000; lookup(q5, 1'b0);
    cfg_base = 40'h03_0000_0000;
    lookup(q0, 1'b0);
    check("R9 same set evicts", {63'd0, g_walk_seen}, 64'd1);
    check("R9 new paddr", 64'(g_pa), 64'(pa_small(q0, 40'h03_0000_0000)));
  endtask

  task automatic t_backpressure();
    logic [VA_W-1:0] e = 39'h40_0000_7000;
    cfg_big = 1'b0; cfg_base = 40'h07_0000_9000;
    cfg_wdelay = 3; cfg_hold = 3;
    lookup(e, 1'b0);
    cfg_wdelay = 0; cfg_hold = 0;
    check("R4 delayed walk result", {62'd0, g_hit, g_walked}, 64'h3);
    check("R1 held response value", 64'(g_pa), 64'(pa_small(e, 40'h07_0000_9000)));
    check("R1 idle after take", {63'd0, req_ready}, 64'd1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_walk_small();
        t_walk_large();
        t_inval();
        t_multi();
        t_promote();
        t_direct_mapped();
        t_backpressure();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule